// File: doc/BRIEF.md
# I2C Serial Clock Divider

This block turns a fast input clock into the serial clock of an I2C master. A programmable prescaler divides the input clock down to a slower module clock, visible as a one-cycle tick. Two programmable counts then set how many module clocks the serial clock spends low and high. Each phase is lengthened by a small fixed offset that the divider adds internally. The offset depends on the prescaler setting, or is a constant in a build-time variant.

A bit engine sits beside the block. It starts the clock with a run request and uses two strobes to place its data changes and samples: one at the end of each low phase and one at the end of each high phase. Software holds the block in its module reset while it loads a new prescaler value. It may change the phase counts at any time; a new count takes effect at the start of the next full serial clock period.

Top module: `scl_divgen`

## Requirements
- R1: While `rst` is high, or from the cycle after `mod_en` is seen low, `scl_o` is 1 and `tick_o`, `low_end_o` and `high_end_o` are 0.
- R2: With `mod_en` high and prescaler value P, `tick_o` is high for exactly one input clock out of every P+1. The first tick appears P+1 clock edges after `mod_en` is first seen high.
- R3: With `FIXED_OFFSET`=0, the phase offset d is 7 when P is 0, 6 when P is 1, and 5 when P is 2 or more.
- R4: With `FIXED_OFFSET`=1, d is 6 for every P.
- R5: The first tick after `run` is seen high while idle starts a low phase, so SCL is driven low first. A low phase lasts (low count + d) ticks, which is (low count + d)·(P+1) input clocks.
- R6: A high phase lasts (high count + d) ticks. A high count of 0 gives a high phase of exactly d ticks.
- R7: `low_end_o` pulses for one cycle in the cycle SCL rises from a low phase. `high_end_o` pulses for one cycle in the cycle a high phase ends. Both pulses fall only on tick boundaries.
- R8: The low and high counts are sampled only at the start of a serial clock period. A change made during a period alters neither of its phases.
- R9: The prescaler value is taken only while `mod_en` is low. Changes made while `mod_en` is high leave the tick period unchanged.
- R10: If `run` falls during a period, that period still completes with both strobes. After it, SCL stays high and no strobe is issued.
- R11: Dropping `mod_en` aborts a period at once: SCL is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_en | input | 1 | Module enable; low holds the divider in reset and admits a new prescaler value |
| run | input | 1 | Request to generate serial clock periods |
| presc | input | CNT_W | Prescaler value P (module clock = clk / (P+1)) |
| low_cnt | input | CNT_W | Low phase count, before offset |
| high_cnt | input | CNT_W | High phase count, before offset |
| scl_o | output | 1 | Serial clock drive level (1 = released high) |
| tick_o | output | 1 | One-cycle module clock tick |
| low_end_o | output | 1 | Strobe at the end of a low phase |
| high_end_o | output | 1 | Strobe at the end of a high phase |

## Verification
The bench builds two copies side by side: one with `FIXED_OFFSET`=0, one with `FIXED_OFFSET`=1. Both see the same stimulus. This shows the prescaler-dependent offsets of 7, 6 and 5 next to the constant 6 in the same run. The default 16-bit width is kept. Small prescaler and count values make each of the three offset cases, a zero high count, mid-period count changes and aborts appear within a few hundred clocks.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam int OFS_W = 3;

  // Phase stretch chosen by the prescaler setting.
  function automatic logic [OFS_W-1:0] phase_offset(input logic [31:0] psc);
    if (psc == 32'd0)      return 3'd7;
    else if (psc == 32'd1) return 3'd6;
    else                   return 3'd5;
  endfunction

endpackage

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] presc_i,
  output logic [CNT_W-1:0] psc_q_o,
  output logic             tick_o
);

  logic [CNT_W-1:0] psc_q;
  logic [CNT_W-1:0] pcnt;
  logic             wrap;

  assign wrap    = (pcnt == psc_q);
  assign psc_q_o = psc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q  <= '0;
      pcnt   <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      psc_q  <= presc_i;
      pcnt   <= '0;
      tick_o <= 1'b0;
    end else if (wrap) begin
      pcnt   <= '0;
      tick_o <= 1'b1;
    end else begin
      pcnt   <= pcnt + CNT_W'(1);
      tick_o <= 1'b0;
    end
  end

  // R9: prescaler frozen while enabled
  p_psc_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (en_i && $past(en_i)) |-> (psc_q == $past(psc_q)));

  // R2: no back-to-back ticks unless dividing by one
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_o && psc_q != '0 && en_i) |=> !tick_o);

  // R1: disabled divider emits no tick
  p_no_tick_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !tick_o);

endmodule

// File: rtl/scl_offset_sel.sv
module scl_offset_sel #(
  parameter int CNT_W        = 16,
  parameter bit FIXED_OFFSET = 1'b0
) (
  input  logic [CNT_W-1:0]            psc_i,
  output logic [scl_pkg::OFS_W-1:0]   ofs_o
);

  generate
    if (FIXED_OFFSET) begin : g_fixed
      logic [CNT_W-1:0] unused_psc;
      assign unused_psc = psc_i;
      assign ofs_o = 3'd6;
    end else begin : g_scaled
      assign ofs_o = scl_pkg::phase_offset(32'(psc_i));
    end
  endgenerate

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en_i,
  input  logic                      run_i,
  input  logic                      tick_i,
  input  logic [scl_pkg::OFS_W-1:0] ofs_i,
  input  logic [CNT_W-1:0]          low_i,
  input  logic [CNT_W-1:0]          high_i,
  output logic                      scl_o,
  output logic                      low_end_o,
  output logic                      high_end_o
);
  import scl_pkg::*;

  localparam int PW = CNT_W + 1;

  phase_e           st;
  logic [PW-1:0]    rem;
  logic [CNT_W-1:0] hi_q;
  logic             phase_done;
  logic             period_start;

  function automatic logic [PW-1:0] span(input logic [CNT_W-1:0] c,
                                         input logic [OFS_W-1:0] d);
    return {1'b0, c} + PW'(d) - PW'(1);
  endfunction

  assign phase_done   = tick_i && (st != PH_IDLE) && (rem == '0);
  assign period_start = tick_i && run_i &&
                        ((st == PH_IDLE) || (st == PH_HIGH && rem == '0));
  assign scl_o        = (st != PH_LOW);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      st         <= PH_IDLE;
      rem        <= '0;
      hi_q       <= '0;
      low_end_o  <= 1'b0;
      high_end_o <= 1'b0;
    end else begin
      low_end_o  <= 1'b0;
      high_end_o <= 1'b0;
      if (period_start) begin
        hi_q <= high_i;
        rem  <= span(low_i, ofs_i);
        st   <= PH_LOW;
        if (st == PH_HIGH) high_end_o <= 1'b1;
      end else if (phase_done) begin
        if (st == PH_LOW) begin
          st        <= PH_HIGH;
          rem       <= span(hi_q, ofs_i);
          low_end_o <= 1'b1;
        end else begin
          st         <= PH_IDLE;
          high_end_o <= 1'b1;
        end
      end else if (tick_i && st != PH_IDLE) begin
        rem <= rem - PW'(1);
      end
    end
  end

  // R7: low-end strobe coincides with a rising serial clock
  p_low_end_rise_r7: assert property (@(posedge clk) disable iff (rst)
    low_end_o |-> (scl_o && !$past(scl_o)));

  // R7: strobes only follow a tick
  p_strobe_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    (low_end_o || high_end_o) |-> $past(tick_i));

  // R5: SCL only falls on a tick boundary
  p_fall_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    (!scl_o && $past(scl_o)) |-> $past(tick_i));

  // R7: the two strobes never coincide
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    !(low_end_o && high_end_o));

  // R11: disable forces SCL high next cycle
  p_abort_high_r11: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> scl_o);

endmodule

// File: rtl/scl_divgen.sv
module scl_divgen #(
  parameter int CNT_W        = 16,
  parameter bit FIXED_OFFSET = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mod_en,
  input  logic             run,
  input  logic [CNT_W-1:0] presc,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  output logic             scl_o,
  output logic             tick_o,
  output logic             low_end_o,
  output logic             high_end_o
);

  logic [CNT_W-1:0]            psc_q;
  logic                        tick;
  logic [scl_pkg::OFS_W-1:0]   ofs;

  scl_tick_gen #(.CNT_W(CNT_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .en_i    (mod_en),
    .presc_i (presc),
    .psc_q_o (psc_q),
    .tick_o  (tick)
  );

  scl_offset_sel #(.CNT_W(CNT_W), .FIXED_OFFSET(FIXED_OFFSET)) u_ofs (
    .psc_i (psc_q),
    .ofs_o (ofs)
  );

  scl_phase_seq #(.CNT_W(CNT_W)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .en_i       (mod_en),
    .run_i      (run),
    .tick_i     (tick),
    .ofs_i      (ofs),
    .low_i      (low_cnt),
    .high_i     (high_cnt),
    .scl_o      (scl_o),
    .low_end_o  (low_end_o),
    .high_end_o (high_end_o)
  );

  assign tick_o = tick;

  // R1: reset leaves SCL released and outputs quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (scl_o && !tick_o && !low_end_o && !high_end_o));

endmodule

// File: tb/scl_divgen_test.sv
module scl_divgen_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, mod_en, run;
  logic [15:0] presc, low_cnt, high_cnt;
  logic        scl [2];
  logic        tk  [2];
  logic        le  [2];
  logic        he  [2];

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  scl_divgen #(.CNT_W(16), .FIXED_OFFSET(1'b0)) uut (
    .clk(clk), .rst(rst), .mod_en(mod_en), .run(run), .presc(presc),
    .low_cnt(low_cnt), .high_cnt(high_cnt), .scl_o(scl[0]), .tick_o(tk[0]),
    .low_end_o(le[0]), .high_end_o(he[0]));

  scl_divgen #(.CNT_W(16), .FIXED_OFFSET(1'b1)) uut_fix (
    .clk(clk), .rst(rst), .mod_en(mod_en), .run(run), .presc(presc),
    .low_cnt(low_cnt), .high_cnt(high_cnt), .scl_o(scl[1]), .tick_o(tk[1]),
    .low_end_o(le[1]), .high_end_o(he[1]));

  // Behavioural reference: one entry per variant (0 scaled, 1 fixed 6)
  int m_pc[2], m_psc[2], m_st[2], m_left[2], m_hi[2];
  bit m_tk[2], m_le[2], m_he[2];

  function automatic int offs(int v, int p);
    if (v == 1) return 6;
    if (p == 0) return 7;
    if (p == 1) return 6;
    return 5;
  endfunction

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      int d;
      d = offs(v, m_psc[v]);
      if (rst || !mod_en) begin
        m_psc[v] = rst ? 0 : int'(presc);
        m_pc[v] = 0; m_tk[v] = 0; m_st[v] = 0; m_left[v] = 0;
        m_hi[v] = 0; m_le[v] = 0; m_he[v] = 0;
      end else begin
        m_le[v] = 0; m_he[v] = 0;
        if (m_tk[v]) begin
          if (m_st[v] == 0) begin
            if (run) begin
              m_hi[v] = int'(high_cnt); m_left[v] = int'(low_cnt) + d - 1; m_st[v] = 1;
            end
          end else if (m_left[v] > 0) begin
            m_left[v] = m_left[v] - 1;
          end else if (m_st[v] == 1) begin
            m_st[v] = 2; m_left[v] = m_hi[v] + d - 1; m_le[v] = 1;
          end else begin
            m_he[v] = 1;
            if (run) begin
              m_hi[v] = int'(high_cnt); m_left[v] = int'(low_cnt) + d - 1; m_st[v] = 1;
            end else m_st[v] = 0;
          end
        end
        if (m_pc[v] == m_psc[v]) begin m_pc[v] = 0; m_tk[v] = 1; end
        else begin m_pc[v] = m_pc[v] + 1; m_tk[v] = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      for (int v = 0; v < 2; v++) begin
        bit exp_scl;
        exp_scl = (m_st[v] != 1);
        checks++;
        if (scl[v] !== exp_scl || tk[v] !== m_tk[v] ||
            le[v] !== m_le[v] || he[v] !== m_he[v]) begin
          errors++;
          $display("FAIL %s model v%0d: scl/tick/le/he got %b%b%b%b exp %b%b%b%b",
                   cur_req, v, scl[v], tk[v], le[v], he[v],
                   exp_scl, m_tk[v], m_le[v], m_he[v]);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind 0: low_end -> high_end (high phase); kind 1: high_end -> low_end (low phase)
  task automatic meas(input int v, input int kind, output int n);
    do @(negedge clk); while (!(kind == 0 ? le[v] : he[v]));
    n = 0;
    do begin @(negedge clk); n++; end while (!(kind == 0 ? he[v] : le[v]));
  endtask

  task automatic tick_gap(input int v, output int n);
    do @(negedge clk); while (!tk[v]);
    n = 0;
    do begin @(negedge clk); n++; end while (!tk[v]);
  endtask

  task automatic reprogram(input int p, input int lo, input int hi);
    @(negedge clk);
    mod_en = 1'b0; presc = 16'(p); low_cnt = 16'(lo); high_cnt = 16'(hi);
    @(negedge clk);
    mod_en = 1'b1; run = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, cnt_le, cnt_he;
    bit quiet;
    rst = 1'b1; mod_en = 1'b0; run = 1'b0;
    presc = 16'd0; low_cnt = 16'd3; high_cnt = 16'd2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    check(scl[0] && scl[1] && !tk[0] && !le[0] && !he[0], "R1 reset idle", int'(scl[0]), 1);

    // Low first after run
    cur_req = "R5";
    mod_en = 1'b1; run = 1'b1;
    @(negedge clk); @(negedge clk);
    check(!scl[0] && !scl[1], "R5 low phase first", int'(scl[0]), 0);

    cur_req = "R3";
    meas(0, 0, n); check(n == 9,  "R3 P=0 high, d=7", n, 9);
    meas(0, 1, n); check(n == 10, "R5 P=0 low, d=7", n, 10);
    cur_req = "R4";
    meas(1, 0, n); check(n == 8,  "R4 fixed high, d=6", n, 8);
    meas(1, 1, n); check(n == 9,  "R4 fixed low, d=6", n, 9);

    cur_req = "R6";
    reprogram(1, 4, 0);
    meas(0, 0, n); check(n == 12, "R6 zero high count P=1", n, 12);
    meas(0, 1, n); check(n == 20, "R3 P=1 low, d=6", n, 20);
    meas(1, 0, n); check(n == 12, "R4 fixed high P=1", n, 12);

    cur_req = "R2";
    reprogram(3, 2, 1);
    tick_gap(0, n); check(n == 4, "R2 tick period P=3", n, 4);
    meas(0, 0, n); check(n == 24, "R3 P=3 high, d=5", n, 24);
    meas(0, 1, n); check(n == 28, "R3 P=3 low, d=5", n, 28);
    meas(1, 1, n); check(n == 32, "R4 fixed low P=3", n, 32);

    cur_req = "R9";
    presc = 16'd0;
    tick_gap(0, n); check(n == 4, "R9 prescaler frozen while enabled", n, 4);

    cur_req = "R8";
    reprogram(0, 3, 2);
    do @(negedge clk); while (!he[0]);
    n = 0;
    do begin @(negedge clk); n++; if (n == 2) low_cnt = 16'd8; end while (!le[0]);
    check(n == 10, "R8 mid-period change ignored", n, 10);
    meas(0, 1, n); check(n == 15, "R8 new low count next period", n, 15);

    cur_req = "R10";
    do @(negedge clk); while (!he[0]);
    run = 1'b0;
    cnt_le = 0; cnt_he = 0;
    repeat (60) begin @(negedge clk); cnt_le += int'(le[0]); cnt_he += int'(he[0]); end
    check(cnt_le == 1 && cnt_he == 1, "R10 period completes after run drop", cnt_le + cnt_he, 2);
    quiet = 1'b1;
    repeat (40) begin @(negedge clk); if (!scl[0] || le[0] || he[0]) quiet = 1'b0; end
    check(quiet, "R10 idle stays high and quiet", int'(quiet), 1);

    cur_req = "R11";
    run = 1'b1;
    do @(negedge clk); while (scl[0]);
    mod_en = 1'b0;
    @(negedge clk);
    check(scl[0] && !tk[0], "R11 abort releases SCL", int'(scl[0]), 1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule